// File: doc/BRIEF.md
# Serial CMOS Sample Serializer

This block turns parallel conversion results from two channels, A and B, into narrow serial streams on up to four single-ended data pins. An external bit clock times the whole block and is also sent back out unchanged as the output bit clock. A frame clock output marks the word boundaries. Each channel has two data pins, a "pin 6" and a "pin 5". A lane-mode input picks one of three formats. Two-wire mode uses both pins of each channel. One-wire mode uses only pin 6 of each channel. Half-wire mode time-multiplexes both channels onto channel A's pin 6.

The upstream logic presents 20-bit samples with a one-cycle valid strobe, and the block keeps the most recent pair. At each frame boundary the block loads a pair into its shift registers and sends the top W bits of each sample, MSB first. W is the output word width, selectable from 14 to 20. Lane mode and width are sampled only at frame boundaries, so a setting can change at any time without breaking a frame. Two-wire mode, which carries the highest sample rates, adds one extra frame of pipeline delay compared with the other two modes.

Top module: `cmos_lane_serializer`

## Requirements
- R1: `dclk_out` always equals `dclk_in`.
- R2: With lane mode 2'b00 (two-wire), a frame lasts ceil(W/2) bit clocks. In clock k of the frame, pin 6 of each channel carries word bit 2k and pin 5 carries word bit 2k+1. Bit 0 is the word MSB. The bit past the end of an odd-width word is sent as 0.
- R3: With lane mode 2'b01 or 2'b11 (one-wire), a frame lasts W bit clocks. In clock k, `a6` and `b6` carry word bit k of their channel, and `a5` and `b5` are low.
- R4: With lane mode 2'b10 (half-wire), a frame lasts 2W bit clocks. `a6` carries the A word in the first W clocks and the B word in the last W clocks. `a5`, `b5` and `b6` are low.
- R5: The output word is the upper W bits of the 20-bit sample. The width input is clamped to the range 14..20.
- R6: In a frame of L clocks, `fclk` is high in clock k exactly when 2k < L. It rises on the first bit of each frame.
- R7: A sample pair is captured on every bit-clock edge where `samp_valid` is high, and it is held until the next capture. A frame boundary uses the pair held before that boundary edge.
- R8: In one-wire and half-wire modes, a frame carries the pair held at its own start. In two-wire mode, a frame carries the pair held at the previous frame's start, which is one frame of extra latency.
- R9: Lane mode and width are sampled only at frame boundaries. A change made inside a frame first affects the next frame.
- R10: While `rst` is high, `fclk` and all data pins are low. The first frame starts at the first edge after reset is released and carries all-zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_in | input | 1 | Bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | Strobe: capture `samp_a`/`samp_b` this edge |
| samp_a | input | 20 | Channel A sample, MSB aligned |
| samp_b | input | 20 | Channel B sample, MSB aligned |
| lane_mode | input | 2 | 00 two-wire, 01/11 one-wire, 10 half-wire |
| word_bits | input | 5 | Output word width, clamped to 14..20 |
| dclk_out | output | 1 | Forwarded bit clock |
| fclk | output | 1 | Frame clock |
| a5 | output | 1 | Channel A data pin 5 |
| a6 | output | 1 | Channel A data pin 6 |
| b5 | output | 1 | Channel B data pin 5 |
| b6 | output | 1 | Channel B data pin 6 |

## Verification
Random 20-bit samples, written in most frames but skipped in some, run through every lane mode at even widths, odd widths, both range limits and out-of-range widths. Odd widths in two-wire mode separate correct zero padding from leaked low sample bits. Frames without a fresh sample show whether the held pair is reused. Changing lane mode or width at the first clock of a frame, with the bench's own frame counter, shows that the running frame keeps its length and format while the next one takes the new setting. Consecutive frames with different samples separate the one-frame latency of two-wire mode from the shorter latency of the other modes.

// File: rtl/cmos_lane_serializer.sv
module cmos_lane_serializer #(
  parameter int SAMP_W = 20,
  parameter int MIN_W  = 14
) (
  input  logic                               dclk_in,
  input  logic                               rst,
  input  logic                               samp_valid,
  input  logic [SAMP_W-1:0]                  samp_a,
  input  logic [SAMP_W-1:0]                  samp_b,
  input  logic [1:0]                         lane_mode,
  input  logic [$clog2(SAMP_W+1)-1:0]        word_bits,
  output logic                               dclk_out,
  output logic                               fclk,
  output logic                               a5,
  output logic                               a6,
  output logic                               b5,
  output logic                               b6
);
  localparam int WB = $clog2(SAMP_W + 1);
  localparam int LW = WB + 1;
  localparam logic [1:0] M_TWO  = 2'b00;
  localparam logic [1:0] M_HALF = 2'b10;

  logic              run;
  logic [1:0]        mode_r;
  logic [WB-1:0]     width_r, width_c;
  logic [LW-1:0]     cnt, flen;
  logic [SAMP_W-1:0] hold_a, hold_b, dly_a, dly_b, sh_a, sh_b;
  logic              two, half, last, load, in_b;

  function automatic logic [SAMP_W-1:0] top_mask(input logic [WB-1:0] w);
    return ~({SAMP_W{1'b1}} >> w);
  endfunction

  always_comb begin
    if (word_bits < WB'(MIN_W))       width_c = WB'(MIN_W);
    else if (word_bits > WB'(SAMP_W)) width_c = WB'(SAMP_W);
    else                              width_c = word_bits;
  end

  assign two  = (mode_r == M_TWO);
  assign half = (mode_r == M_HALF);

  always_comb begin
    if (two)       flen = LW'((width_r + WB'(1)) >> 1);
    else if (half) flen = {width_r, 1'b0};
    else           flen = LW'(width_r);
  end

  assign last = (cnt == flen - LW'(1));
  assign load = !run || last;
  assign in_b = half && (cnt >= LW'(width_r));

  always_ff @(posedge dclk_in) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (samp_valid) begin
      hold_a <= samp_a;
      hold_b <= samp_b;
    end
  end

  always_ff @(posedge dclk_in) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      mode_r  <= M_TWO;
      width_r <= WB'(SAMP_W);
      dly_a   <= '0;
      dly_b   <= '0;
      sh_a    <= '0;
      sh_b    <= '0;
    end else if (load) begin
      run     <= 1'b1;
      cnt     <= '0;
      mode_r  <= lane_mode;
      width_r <= width_c;
      dly_a   <= hold_a;
      dly_b   <= hold_b;
      sh_a    <= ((lane_mode == M_TWO) ? dly_a : hold_a) & top_mask(width_c);
      sh_b    <= ((lane_mode == M_TWO) ? dly_b : hold_b) & top_mask(width_c);
    end else begin
      cnt <= cnt + LW'(1);
      if (two) begin
        sh_a <= sh_a << 2;
        sh_b <= sh_b << 2;
      end else if (half) begin
        if (in_b) sh_b <= sh_b << 1;
        else      sh_a <= sh_a << 1;
      end else begin
        sh_a <= sh_a << 1;
        sh_b <= sh_b << 1;
      end
    end
  end

  assign dclk_out = dclk_in;
  assign fclk     = run && ({cnt, 1'b0} < {1'b0, flen});
  assign a6       = in_b ? sh_b[SAMP_W-1] : sh_a[SAMP_W-1];
  assign a5       = two && sh_a[SAMP_W-2];
  assign b6       = !half && sh_b[SAMP_W-1];
  assign b5       = two && sh_b[SAMP_W-2];
endmodule

// File: rtl/cmos_lane_serializer_chk.sv
module cmos_lane_serializer_chk #(
  parameter int SAMP_W = 20,
  parameter int MIN_W  = 14,
  parameter int WB     = 5,
  parameter int LW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [LW-1:0]     cnt,
  input logic [LW-1:0]     flen,
  input logic [1:0]        mode_r,
  input logic [WB-1:0]     width_r,
  input logic              samp_valid,
  input logic [SAMP_W-1:0] samp_a,
  input logic [SAMP_W-1:0] hold_a,
  input logic              fclk,
  input logic              a5,
  input logic              b5
);
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (run && mode_r == 2'b00 && width_r[0] && cnt == flen - LW'(1)) |-> (!a5 && !b5));

  assert_width_range_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (width_r >= WB'(MIN_W) && width_r <= WB'(SAMP_W)));

  assert_fclk_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fclk) |-> (!$past(run) || $past(cnt) == $past(flen) - LW'(1)));

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(samp_valid)) |-> (hold_a == $past(samp_a)));

  assert_cfg_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && run && $past(run) && cnt != '0) |-> ($stable(mode_r) && $stable(width_r)));
endmodule

bind cmos_lane_serializer cmos_lane_serializer_chk #(
  .SAMP_W(SAMP_W), .MIN_W(MIN_W), .WB(WB), .LW(LW)
) i_chk (
  .clk(dclk_in), .rst(rst), .run(run), .cnt(cnt), .flen(flen),
  .mode_r(mode_r), .width_r(width_r), .samp_valid(samp_valid),
  .samp_a(samp_a), .hold_a(hold_a), .fclk(fclk), .a5(a5), .b5(b5)
);

// File: tb/test_cmos_lane_serializer.sv
module test_cmos_lane_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp_valid = 1'b0;
  logic [19:0] samp_a = '0, samp_b = '0;
  logic [1:0]  lane_mode = 2'b00;
  logic [4:0]  word_bits = 5'd16;
  logic        dclk_out, fclk, a5, a6, b5, b6;

  int checks = 0, errors = 0;
  int frame_no = 0;
  int fm, fw;
  logic [19:0] w1a = '0, w1b = '0, w2a = '0, w2b = '0, ha = '0, hb = '0;

  always #10 clk = ~clk;

  cmos_lane_serializer i_cmos_lane_serializer (
    .dclk_in(clk), .rst(rst), .samp_valid(samp_valid), .samp_a(samp_a),
    .samp_b(samp_b), .lane_mode(lane_mode), .word_bits(word_bits),
    .dclk_out(dclk_out), .fclk(fclk), .a5(a5), .a6(a6), .b5(b5), .b6(b6)
  );

  function automatic int clampw(input int w);
    return (w < 14) ? 14 : (w > 20) ? 20 : w;
  endfunction

  function automatic int mkind(input int m);
    return (m == 0) ? 0 : (m == 2) ? 2 : 1;
  endfunction

  function automatic int flen_of(input int m, input int w);
    return (m == 0) ? (w + 1) / 2 : (m == 2) ? 2 * w : w;
  endfunction

  function automatic logic wbit(input logic [19:0] s, input int w, input int i);
    return (i < w) ? s[19 - i] : 1'b0;
  endfunction

  function automatic logic [4:0] exp_pins(input int m, input int w, input int k,
                                          input logic [19:0] ea, input logic [19:0] eb);
    logic f, pa6, pa5, pb6, pb5;
    int len;
    len = flen_of(m, w);
    f = (2 * k < len);
    pa5 = 1'b0; pb5 = 1'b0; pb6 = 1'b0;
    if (m == 0) begin
      pa6 = wbit(ea, w, 2 * k);
      pa5 = wbit(ea, w, 2 * k + 1);
      pb6 = wbit(eb, w, 2 * k);
      pb5 = wbit(eb, w, 2 * k + 1);
    end else if (m == 1) begin
      pa6 = wbit(ea, w, k);
      pb6 = wbit(eb, w, k);
    end else begin
      pa6 = (k < w) ? wbit(ea, w, k) : wbit(eb, w, k - w);
    end
    return {f, pa6, pa5, pb6, pb5};
  endfunction

  // One frame, entered at the negedge of its first clock. At that point the
  // next frame's settings are driven (R9) and maybe a new sample (R7).
  task automatic run_frame(input int nm, input int nw, input bit wr);
    int len;
    logic [19:0] ea, eb;
    logic [4:0] got, exp;
    bit bad;
    string req;
    len = flen_of(fm, fw);
    // R8: two-wire carries the pair held one frame earlier
    ea = (fm == 0) ? w2a : w1a;
    eb = (fm == 0) ? w2b : w1b;
    req = (fm == 0) ? "R2" : (fm == 1) ? "R3" : "R4";
    bad = 0;
    for (int k = 0; k < len; k++) begin
      got = {fclk, a6, a5, b6, b5};
      exp = exp_pins(fm, fw, k, ea, eb);
      if (got !== exp && !bad) begin
        bad = 1;
        // R5 word bits, R6 fclk, R9 format held for whole frame
        $display("FAIL %s/R5/R6/R8/R9 frame %0d mode %0d width %0d clk %0d: {fclk,a6,a5,b6,b5} got %b exp %b",
                 req, frame_no, fm, fw, k, got, exp);
      end
      if (k == 0) begin
        lane_mode = 2'(nm);
        word_bits = 5'(nw);
        if (wr) begin
          samp_a = 20'($urandom);
          samp_b = 20'($urandom);
          samp_valid = 1'b1;
          ha = samp_a;
          hb = samp_b;
        end
      end
      @(negedge clk);
      samp_valid = 1'b0;
    end
    checks++;
    if (bad) errors++;
    w2a = w1a; w2b = w1b;
    w1a = ha;  w1b = hb;
    fm = mkind(nm);
    fw = clampw(nw);
    frame_no++;
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    // R10: outputs quiet in reset
    repeat (3) @(negedge clk);
    checks++;
    if ({fclk, a6, a5, b6, b5} !== 5'b0) begin
      errors++;
      $display("FAIL R10 reset pins got %b exp %b", {fclk, a6, a5, b6, b5}, 5'b0);
    end
    // R1: forwarded clock, both phases
    checks++;
    if (dclk_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 dclk_out low phase got %b exp 0", dclk_out);
    end
    @(posedge clk); #5;
    checks++;
    if (dclk_out !== 1'b1) begin
      errors++;
      $display("FAIL R1 dclk_out high phase got %b exp 1", dclk_out);
    end
    @(negedge clk);
    lane_mode = 2'b00;
    word_bits = 5'd16;
    fm = 0; fw = 16;
    rst = 1'b0;
    @(negedge clk);
    // R10: first frame starts here with zero words
    repeat (4) run_frame(0, 16, 1);
    repeat (4) run_frame(0, 15, 1);   // R2 odd-width padding
    repeat (4) run_frame(1, 20, 1);   // R3 at the top width
    repeat (4) run_frame(2, 14, 1);   // R4 at the bottom width
    repeat (3) run_frame(3, 17, 1);   // R3 code 11
    repeat (3) run_frame(0, 10, 1);   // R5 clamp low
    repeat (3) run_frame(1, 25, 1);   // R5 clamp high
    repeat (3) run_frame(2, 19, 0);   // R7 held pair reused
    repeat (3) run_frame(2, 19, 1);
    for (int i = 0; i < 40; i++)
      run_frame(int'($urandom_range(0, 3)), int'($urandom_range(12, 23)),
                bit'($urandom_range(0, 3) != 0));
    repeat (3) run_frame(0, 14, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule